// File: doc/BRIEF.md
# Coprocessor Command Issue Sequencer

This block sits between a CPU and a coprocessor and decides when the coprocessor is ready for more work. The CPU presents one command per cycle. Each command has a kind, a tag and, for unit instructions, a latency in cycles. There are three kinds of command: configuration writes, control/status-register writes and unit instructions. The sequencer runs them one at a time, in issue order, through a single execution slot. Each command keeps the slot for its own number of cycles. A configuration write takes a fixed six cycles and a status write takes a fixed two. An instruction takes the latency supplied with it. The CPU works out that latency from the opcode, for example a pause count or the outcome of a conditional move.

Commands that arrive while the slot is occupied wait in a small ordered queue. Two kinds of arrival change what is pending. A configuration write that arrives while work is outstanding is refused with an error, and everything outstanding is thrown away. A status write whose predecessor in the queue is another status write that has not yet started takes that predecessor's place. The CPU sees a ready/stall signal, a busy flag, a one-cycle error pulse with a code, and a one-cycle retire pulse carrying the tag and kind of each completed command.

Top module: `copro_issue_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy is 0, cmdReady is 1, errPulse is 0 and retireValid is 0.
- R2: A configuration write (cmdKind 2) that is accepted while busy is 0 produces no error. It holds busy high for exactly CFG_CYCLES cycles (default 6), starting in the cycle after it is accepted.
- R3: A status write (cmdKind 1) occupies the slot for STAT_CYCLES cycles (default 2). It never raises an error, even when it is accepted while busy. It runs only after every command accepted before it.
- R4: An instruction (cmdKind 0) occupies the slot for cmdLatency cycles. A latency of 0 still occupies it for one cycle.
- R5: Queued commands run back to back with no idle cycle between them. From the first acceptance into an idle unit, busy stays high for the sum of the commands' slot times.
- R6: A configuration write accepted while busy is 1 drives errPulse for one cycle with errCode 2, in the cycle after acceptance. In that same cycle busy is 0. The executing command and all queued commands are discarded without retiring, and the refused write itself never executes.
- R7: If a status write is accepted while the most recently queued command is a status write that has not started executing, the older one is dropped. It never retires and uses no cycles.
- R8: Two status writes with an instruction accepted between them both execute and both retire.
- R9: The queue holds DEPTH commands (default 4) besides the one executing. cmdReady is 0 exactly when the queue is full, and a command is accepted only in a cycle where cmdValid and cmdReady are both 1.
- R10: Each completed command drives retireValid for one cycle, in the cycle after its last slot cycle, with its cmdTag on retireTag and its kind on retireKind. Retirements follow acceptance order.
- R11: A command with cmdKind 3 is refused. The next cycle carries errPulse with errCode 1. The command is neither queued nor executed, and the pending work is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdKind | input | 2 | 0 instruction, 1 status write, 2 configuration write, 3 reserved |
| cmdTag | input | TAG_W | Identifier returned at retirement |
| cmdLatency | input | LAT_W | Slot cycles for an instruction |
| cmdReady | output | 1 | Queue has room; command is accepted when valid and ready |
| busy | output | 1 | A command is executing or waiting |
| errPulse | output | 1 | One-cycle error indication |
| errCode | output | 2 | 1 reserved kind, 2 configuration write while busy |
| retireValid | output | 1 | One-cycle completion strobe |
| retireKind | output | 2 | Kind of the completed command |
| retireTag | output | TAG_W | Tag of the completed command |

## Verification
The bench targets the configuration write that arrives with work in flight. A design that only cleared the queue would still retire the executing instruction, and one that accepted the write would stay busy for six more cycles. It issues two status writes back to back behind a long instruction. A missing replacement shows up as an extra retirement and two extra busy cycles, and replacing across an intervening instruction would lose a retirement. It fills the queue to check the stall, and runs zero-latency instructions, which a design that counted to zero would finish in no cycles and so break the busy-time sum. Random mixes, checked against tag order and total busy time, catch any gap or overlap between consecutive commands.

// File: rtl/copro_issue_pkg.sv
package copro_issue_pkg;

  typedef enum logic [1:0] {
    KIND_INSTR  = 2'd0,
    KIND_STATUS = 2'd1,
    KIND_CONFIG = 2'd2,
    KIND_RSVD   = 2'd3
  } cmd_kind_e;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_BAD_KIND = 2'd1;
  localparam logic [1:0] ERR_CFG_BUSY = 2'd2;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;     // append incoming command to queue
    logic replace;  // overwrite queued tail status write
    logic pop;      // move queue head into execution slot
    logic load;     // move incoming command straight into slot
    logic tick;     // count down the slot
    logic finish;   // slot command completes, retire it
    logic flush;    // discard queue and slot
  } seq_ctrl_t;

endpackage

// File: rtl/copro_issue_dp.sv
module copro_issue_dp
  import copro_issue_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int TAG_W       = 8,
  parameter int LAT_W       = 5,
  parameter int CFG_CYCLES  = 6,
  parameter int STAT_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_ctrl_t        ctrl,
  input  logic [1:0]       inKind,
  input  logic [TAG_W-1:0] inTag,
  input  logic [LAT_W-1:0] inLat,
  output logic             empty,
  output logic             full,
  output logic             oneLeft,
  output logic             tailIsStatus,
  output logic             cntLow,
  output logic             retireValid,
  output logic [1:0]       retireKind,
  output logic [TAG_W-1:0] retireTag
);

  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int QCNT_W  = $clog2(DEPTH + 1);
  localparam int FIX_MAX = (CFG_CYCLES > STAT_CYCLES) ? CFG_CYCLES : STAT_CYCLES;
  localparam int FIX_W   = $clog2(FIX_MAX + 1);
  localparam int EXE_W   = (LAT_W > FIX_W) ? LAT_W : FIX_W;

  logic [1:0]       qKind [DEPTH];
  logic [TAG_W-1:0] qTag  [DEPTH];
  logic [LAT_W-1:0] qLat  [DEPTH];

  logic [PTR_W-1:0]  wrPtr, rdPtr, tailPtr;
  logic [QCNT_W-1:0] qCount;

  logic [EXE_W-1:0] exeCnt;
  logic [1:0]       exeKind;
  logic [TAG_W-1:0] exeTag;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [EXE_W-1:0] slotCost(input logic [1:0] k, input logic [LAT_W-1:0] lat);
    case (cmd_kind_e'(k))
      KIND_CONFIG: return EXE_W'(CFG_CYCLES);
      KIND_STATUS: return EXE_W'(STAT_CYCLES);
      default:     return EXE_W'(lat);
    endcase
  endfunction

  assign tailPtr      = (wrPtr == '0) ? PTR_W'(DEPTH - 1) : wrPtr - 1'b1;
  assign empty        = (qCount == '0);
  assign full         = (qCount == QCNT_W'(DEPTH));
  assign oneLeft      = (qCount == QCNT_W'(1));
  assign tailIsStatus = !empty && (qKind[tailPtr] == KIND_STATUS);
  assign cntLow       = (exeCnt <= EXE_W'(1));

  // queue storage, no reset needed
  always_ff @(posedge clk) begin
    if (ctrl.push) begin
      qKind[wrPtr] <= inKind;
      qTag[wrPtr]  <= inTag;
      qLat[wrPtr]  <= inLat;
    end
    if (ctrl.replace) begin
      qTag[tailPtr] <= inTag;
    end
  end

  // queue pointers
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (ctrl.push) wrPtr <= nextPtr(wrPtr);
      if (ctrl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctrl.push, ctrl.pop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // execution slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exeCnt  <= '0;
      exeKind <= '0;
      exeTag  <= '0;
    end else if (ctrl.load) begin
      exeCnt  <= slotCost(inKind, inLat);
      exeKind <= inKind;
      exeTag  <= inTag;
    end else if (ctrl.pop) begin
      exeCnt  <= slotCost(qKind[rdPtr], qLat[rdPtr]);
      exeKind <= qKind[rdPtr];
      exeTag  <= qTag[rdPtr];
    end else if (ctrl.tick) begin
      exeCnt <= exeCnt - 1'b1;
    end
  end

  // retire strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      retireValid <= 1'b0;
      retireKind  <= '0;
      retireTag   <= '0;
    end else begin
      retireValid <= ctrl.finish;
      if (ctrl.finish) begin
        retireKind <= exeKind;
        retireTag  <= exeTag;
      end
    end
  end

endmodule

// File: rtl/copro_issue_ctl.sv
module copro_issue_ctl
  import copro_issue_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  input  logic       empty,
  input  logic       full,
  input  logic       oneLeft,
  input  logic       tailIsStatus,
  input  logic       cntLow,
  output seq_ctrl_t  ctrl,
  output logic       cmdReady,
  output logic       busy,
  output logic       errPulse,
  output logic [1:0] errCode
);

  cmd_kind_e kind;
  logic active;
  logic accept, badKind, cfgClash, goodCmd;
  logic finishNow, freeNow, popNow, replaceNow, loadNow;

  assign kind     = cmd_kind_e'(cmdKind);
  assign cmdReady = !full;
  assign busy     = active || !empty;

  always_comb begin
    accept     = cmdValid && cmdReady;
    badKind    = accept && (kind == KIND_RSVD);
    cfgClash   = accept && (kind == KIND_CONFIG) && busy;
    goodCmd    = accept && !badKind && !cfgClash;
    finishNow  = active && cntLow;
    freeNow    = !active || finishNow;
    popNow     = freeNow && !empty;
    // tail equals head when one entry is left; if head leaves now it has started
    replaceNow = goodCmd && (kind == KIND_STATUS) && tailIsStatus && !(popNow && oneLeft);
    loadNow    = goodCmd && !replaceNow && empty && freeNow;

    ctrl       = '0;
    ctrl.flush = cfgClash;
    if (!cfgClash) begin
      ctrl.finish  = finishNow;
      ctrl.tick    = active && !cntLow;
      ctrl.pop     = popNow;
      ctrl.replace = replaceNow;
      ctrl.load    = loadNow;
      ctrl.push    = goodCmd && !replaceNow && !loadNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (cfgClash) begin
      active <= 1'b0;
    end else if (loadNow || popNow) begin
      active <= 1'b1;
    end else if (finishNow) begin
      active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      errPulse <= badKind || cfgClash;
      errCode  <= cfgClash ? ERR_CFG_BUSY : (badKind ? ERR_BAD_KIND : ERR_NONE);
    end
  end

endmodule

// File: rtl/copro_issue_seq.sv
module copro_issue_seq
  import copro_issue_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int TAG_W       = 8,
  parameter int LAT_W       = 5,
  parameter int CFG_CYCLES  = 6,
  parameter int STAT_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdKind,
  input  logic [TAG_W-1:0] cmdTag,
  input  logic [LAT_W-1:0] cmdLatency,
  output logic             cmdReady,
  output logic             busy,
  output logic             errPulse,
  output logic [1:0]       errCode,
  output logic             retireValid,
  output logic [1:0]       retireKind,
  output logic [TAG_W-1:0] retireTag
);

  seq_ctrl_t ctrl;
  logic empty, full, oneLeft, tailIsStatus, cntLow;

  copro_issue_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdKind      (cmdKind),
    .empty        (empty),
    .full         (full),
    .oneLeft      (oneLeft),
    .tailIsStatus (tailIsStatus),
    .cntLow       (cntLow),
    .ctrl         (ctrl),
    .cmdReady     (cmdReady),
    .busy         (busy),
    .errPulse     (errPulse),
    .errCode      (errCode)
  );

  copro_issue_dp #(
    .DEPTH       (DEPTH),
    .TAG_W       (TAG_W),
    .LAT_W       (LAT_W),
    .CFG_CYCLES  (CFG_CYCLES),
    .STAT_CYCLES (STAT_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .inKind       (cmdKind),
    .inTag        (cmdTag),
    .inLat        (cmdLatency),
    .empty        (empty),
    .full         (full),
    .oneLeft      (oneLeft),
    .tailIsStatus (tailIsStatus),
    .cntLow       (cntLow),
    .retireValid  (retireValid),
    .retireKind   (retireKind),
    .retireTag    (retireTag)
  );

endmodule

// File: rtl/copro_issue_chk.sv
module copro_issue_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdKind,
  input logic       cmdReady,
  input logic       busy,
  input logic       errPulse,
  input logic [1:0] errCode,
  input logic       retireValid
);

  logic accepted;
  assign accepted = cmdValid && cmdReady;

  // R6
  cfg_clash_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && cmdKind == 2'd2 && busy |=> errPulse && errCode == 2'd2);

  // R6
  cfg_clash_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && cmdKind == 2'd2 && busy |=> !busy && !retireValid);

  // R2
  cfg_idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && cmdKind == 2'd2 && !busy |=> busy && !errPulse);

  // R3
  status_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && cmdKind == 2'd1 |=> !errPulse);

  // R11
  bad_kind_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && cmdKind == 2'd3 |=> errPulse && errCode == 2'd1);

  // R9
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> cmdReady);

  // R10
  retire_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireValid && !busy |=> !retireValid);

endmodule

bind copro_issue_seq copro_issue_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdKind     (cmdKind),
  .cmdReady    (cmdReady),
  .busy        (busy),
  .errPulse    (errPulse),
  .errCode     (errCode),
  .retireValid (retireValid)
);

// File: tb/copro_issue_seq_tb.sv
`timescale 1ns/1ps
module copro_issue_seq_tb;

  localparam int TAG_W = 8;
  localparam int LAT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdKind = '0;
  logic [TAG_W-1:0] cmdTag = '0;
  logic [LAT_W-1:0] cmdLatency = '0;
  logic cmdReady, busy, errPulse, retireValid;
  logic [1:0] errCode, retireKind;
  logic [TAG_W-1:0] retireTag;

  always #2 clk = ~clk;

  copro_issue_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdTag(cmdTag), .cmdLatency(cmdLatency), .cmdReady(cmdReady),
    .busy(busy), .errPulse(errPulse), .errCode(errCode),
    .retireValid(retireValid), .retireKind(retireKind), .retireTag(retireTag)
  );

  int nChecks = 0;
  int nFails = 0;

  // observation counters
  int busyCycles = 0;
  int retCount = 0;
  int errCount = 0;
  int lastErr = 0;
  int retTags [64];
  int retKinds [64];

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCycles++;
      if (retireValid) begin
        if (retCount < 64) begin
          retTags[retCount]  = int'(retireTag);
          retKinds[retCount] = int'(retireKind);
        end
        retCount++;
      end
      if (errPulse) begin
        errCount++;
        lastErr = int'(errCode);
      end
    end
  end

  function automatic int slotOf(int kind, int lat);
    if (kind == 2) return 6;
    if (kind == 1) return 2;
    return (lat == 0) ? 1 : lat;
  endfunction

  task automatic checkEq(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    busyCycles = 0;
    retCount = 0;
    errCount = 0;
    lastErr = 0;
  endtask

  task automatic issue(int kind, int tag, int lat);
    @(negedge clk);
    cmdValid = 1'b0;
    while (!cmdReady) @(negedge clk);
    cmdKind = 2'(kind);
    cmdTag = TAG_W'(tag);
    cmdLatency = LAT_W'(lat);
    cmdValid = 1'b1;
  endtask

  task automatic endIssue();
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    endIssue();
    while (busy) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    checkEq("R1", "busy in reset", int'(busy), 0);
    checkEq("R1", "cmdReady in reset", int'(cmdReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "busy after reset", int'(busy), 0);
    checkEq("R1", "errPulse after reset", int'(errPulse), 0);
    checkEq("R1", "retireValid after reset", int'(retireValid), 0);
    clearMon();

    // R2 configuration write on idle unit, R10 retire kind
    issue(2, 5, 0);
    waitIdle();
    checkEq("R2", "config busy cycles", busyCycles, slotOf(2, 0));
    checkEq("R2", "config error count", errCount, 0);
    checkEq("R10", "config retire count", retCount, 1);
    checkEq("R10", "config retire tag", retTags[0], 5);
    checkEq("R10", "config retire kind", retKinds[0], 2);
    clearMon();

    // R3 status write idle
    issue(1, 6, 0);
    waitIdle();
    checkEq("R3", "status busy cycles", busyCycles, 2);
    checkEq("R10", "status retire kind", retKinds[0], 1);
    clearMon();

    // R4 instruction latencies, including zero
    issue(0, 7, 5);
    waitIdle();
    checkEq("R4", "latency 5 busy cycles", busyCycles, 5);
    clearMon();
    issue(0, 8, 0);
    waitIdle();
    checkEq("R4", "latency 0 busy cycles", busyCycles, 1);
    checkEq("R4", "latency 0 retire", retCount, 1);
    clearMon();

    // R3 status behind a busy instruction, no error, ordered after
    issue(0, 10, 4);
    issue(1, 11, 0);
    waitIdle();
    checkEq("R3", "status while busy errors", errCount, 0);
    checkEq("R3", "busy total", busyCycles, 6);
    checkEq("R3", "first retire", retTags[0], 10);
    checkEq("R3", "second retire", retTags[1], 11);
    clearMon();

    // R7 superseded status write
    issue(0, 20, 10);
    issue(1, 21, 0);
    issue(1, 22, 0);
    waitIdle();
    checkEq("R7", "retire count", retCount, 2);
    checkEq("R7", "busy total", busyCycles, 12);
    checkEq("R7", "surviving tag", retTags[1], 22);
    checkEq("R7", "errors", errCount, 0);
    clearMon();

    // R8 instruction between status writes
    issue(0, 30, 3);
    issue(1, 31, 0);
    issue(0, 32, 2);
    issue(1, 33, 0);
    waitIdle();
    checkEq("R8", "retire count", retCount, 4);
    checkEq("R8", "busy total", busyCycles, 9);
    checkEq("R8", "order tag1", retTags[1], 31);
    checkEq("R8", "order tag3", retTags[3], 33);
    clearMon();

    // R6 configuration write while busy
    issue(0, 40, 10);
    issue(0, 41, 1);
    issue(2, 42, 0);
    endIssue();
    checkEq("R6", "busy right after clash", int'(busy), 0);
    checkEq("R6", "errPulse after clash", int'(errPulse), 1);
    waitIdle();
    checkEq("R6", "error count", errCount, 1);
    checkEq("R6", "error code", lastErr, 2);
    checkEq("R6", "retires after flush", retCount, 0);
    checkEq("R6", "busy cycles", busyCycles, 2);
    clearMon();

    // R11 reserved kind
    issue(0, 50, 3);
    issue(3, 51, 0);
    waitIdle();
    checkEq("R11", "error count", errCount, 1);
    checkEq("R11", "error code", lastErr, 1);
    checkEq("R11", "pending untouched retires", retCount, 1);
    checkEq("R11", "busy cycles", busyCycles, 3);
    clearMon();

    // R9 queue full stalls
    issue(0, 60, 30);
    for (int i = 1; i <= 4; i++) issue(0, 60 + i, 1);
    endIssue();
    checkEq("R9", "cmdReady when full", int'(cmdReady), 0);
    waitIdle();
    checkEq("R9", "retire count", retCount, 5);
    checkEq("R5", "busy total full queue", busyCycles, 34);
    checkEq("R9", "cmdReady after drain", int'(cmdReady), 1);
    clearMon();

    // R5, R10 random mixes
    for (int round = 0; round < 25; round++) begin
      int n;
      int expBusy;
      int bad;
      int prevStat;
      int kinds [8];
      n = 3 + int'($urandom % 6);
      expBusy = 0;
      prevStat = 0;
      for (int i = 0; i < n; i++) begin
        int lat;
        lat = int'($urandom % 9);
        if (!prevStat && ($urandom % 3) == 0) kinds[i] = 1;
        else kinds[i] = 0;
        prevStat = (kinds[i] == 1) ? 1 : 0;
        expBusy += slotOf(kinds[i], lat);
        issue(kinds[i], 100 + i, lat);
      end
      waitIdle();
      checkEq("R5", "random busy total", busyCycles, expBusy);
      checkEq("R10", "random retire count", retCount, n);
      bad = 0;
      for (int i = 0; i < n; i++) begin
        if (retTags[i] != 100 + i || retKinds[i] != kinds[i]) bad++;
      end
      checkEq("R10", "random retire order mismatches", bad, 0);
      clearMon();
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule